// File: doc/BRIEF.md
# Channel-gain scan sequencer

This block keeps a short list of analog-input settings, each made of a channel number, a gain code and an end-of-list marker, and presents one setting at a time to the input multiplexer and the programmable-gain stage. Conversion triggers from an external timer move through the list. When the sequencer reaches an entry that carries the end marker, it returns to the head of the list and emits a one-cycle scan-boundary pulse.

Software uses a small write-only register port. It writes a slot number to the index register, which also repositions the sequencer. It writes an entry word to the entry register. It sets the mode through the control register. With scanning switched off, the most recently written entry word stays applied no matter how many conversions occur. An optional scan gate holds off conversions after each completed scan until an external scan-start pulse arrives.

Top module: `cgs_sequencer`

## Requirements
- R1: After reset, scanning, the scan gate and differential mode are all off, and the static entry is zero. As a result mux_sel is 0, gain_code is 0 and scan_done is 0.
- R2: An entry word holds the channel in bits 3:0, the end marker in bit 4 and the gain code in bits 7:6. When control bit 0 is 0, the outputs show the last word written to the entry register, and conversions change neither the outputs nor scan_done.
- R3: The register select wr_sel works as follows:
  - 0 selects the index register.
  - 1 selects the entry register.
  - 2 selects the control register: bit 0 enables scanning, bit 1 enables the scan gate, bit 2 enables differential mode.
  An entry write stores into the slot at the current pointer. The pointer does not move on an entry write, and the other slots are unchanged.
- R4: When scanning is enabled, mux_sel and gain_code show the entry at the pointer in the same cycle. Each accepted conversion moves the pointer on by one at the next clock edge.
- R5: An accepted conversion on an entry that carries the end marker returns the pointer to slot 0. It also drives scan_done high for exactly the following cycle.
- R6: An accepted conversion on the highest slot returns the pointer to slot 0 even when that slot has no end marker. In that case scan_done stays low.
- R7: An index write loads the pointer at the next edge, also while scanning is enabled. It wins over a conversion in the same cycle and clears a scan-gate hold.
- R8: When the scan gate is enabled, a completed scan sets a hold. While the hold is set, conv_go stays low and the pointer stays put. A scan_start pulse clears the hold at the next edge.
- R9: When differential mode is enabled, mux_sel bit 3 is forced to 0, which leaves 8 selectable inputs.
- R10: conv_go follows conv_pulse in the same cycle whenever no hold is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 index, 1 entry, 2 control |
| wr_data | input | 16 | Register write data |
| conv_pulse | input | 1 | One-cycle conversion trigger from the sample timer |
| scan_start | input | 1 | One-cycle scan-start pulse that releases a gate hold |
| conv_go | output | 1 | Conversion trigger passed on to the converter |
| mux_sel | output | 4 | Multiplexer channel select |
| gain_code | output | 2 | Gain stage code |
| scan_done | output | 1 | One-cycle scan-boundary pulse |

## Verification
The bench builds the sequencer with an eight-slot list rather than the sixteen-slot default. With eight slots, the wrap at the highest slot without an end marker (R6) takes only four conversions from slot 4. The short list also lets the whole list, together with a region that carries no marker, be loaded and walked in a few hundred cycles. Entry values are chosen so that the channel field sets bit 3, which makes the differential-mode masking visible on mux_sel.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  localparam int ENTRY_W  = 16;
  localparam int CHAN_W   = 4;
  localparam int GAIN_W   = 2;
  localparam int LAST_BIT = 4;
  localparam int GAIN_LSB = 6;

  localparam int CTRL_SCAN = 0;
  localparam int CTRL_GATE = 1;
  localparam int CTRL_DIFF = 2;
  localparam int CTRL_W    = 3;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_ENTRY = 2'd1,
    SEL_CTRL  = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic              last;
    logic [CHAN_W-1:0] chan;
  } entry_t;
endpackage

// File: rtl/cgs_cfg_regs.sv
module cgs_cfg_regs
  import cgs_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic               scan_en,
  output logic               gate_en,
  output logic               diff_en,
  output entry_t             static_entry,
  output entry_t             wr_entry,
  output logic               idx_wr,
  output logic [PTR_W-1:0]   idx_val,
  output logic               entry_wr
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  entry_t            static_q, static_d;
  logic              ctrl_wr;
  logic [ENTRY_W-1:0] unused_wr_bits;

  assign unused_wr_bits = {wr_data[ENTRY_W-1:GAIN_LSB+GAIN_W], wr_data[LAST_BIT+1], 8'd0};

  assign idx_wr   = wr_en && (wr_sel == SEL_INDEX);
  assign entry_wr = wr_en && (wr_sel == SEL_ENTRY);
  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  assign idx_val  = wr_data[PTR_W-1:0];

  always_comb begin
    wr_entry.chan = wr_data[CHAN_W-1:0];
    wr_entry.last = wr_data[LAST_BIT];
    wr_entry.gain = wr_data[GAIN_LSB +: GAIN_W];
  end

  always_comb begin
    ctrl_d   = ctrl_q;
    static_d = static_q;
    if (ctrl_wr)  ctrl_d   = wr_data[CTRL_W-1:0];
    if (entry_wr) static_d = wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      static_q <= '0;
    end else begin
      if (ctrl_wr)  ctrl_q   <= ctrl_d;
      if (entry_wr) static_q <= static_d;
    end
  end

  assign scan_en      = ctrl_q[CTRL_SCAN];
  assign gate_en      = ctrl_q[CTRL_GATE];
  assign diff_en      = ctrl_q[CTRL_DIFF];
  assign static_entry = static_q;
endmodule

// File: rtl/cgs_entry_ram.sv
module cgs_entry_ram
  import cgs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  entry_t           wdata,
  input  logic [PTR_W-1:0] raddr,
  output entry_t           rdata
);
  entry_t rows [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    entry_t row_q;
    logic   row_we;
    assign row_we = we && (waddr == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (row_we) row_q <= wdata;
    end
    assign rows[i] = row_q;
  end

  assign rdata = rows[raddr];
endmodule

// File: rtl/cgs_ptr_ctrl.sv
module cgs_ptr_ctrl #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             gate_en,
  input  logic             conv_pulse,
  input  logic             scan_start,
  input  logic             idx_wr,
  input  logic [PTR_W-1:0] idx_val,
  input  logic             cur_last,
  output logic [PTR_W-1:0] ptr,
  output logic             conv_go,
  output logic             scan_done
);
  localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             held_q, held_d;
  logic             done_q, done_d;
  logic             adv, wrap;

  assign conv_go = conv_pulse && !held_q;
  assign adv     = conv_go && scan_en;
  assign wrap    = cur_last || (ptr_q == TOP_IDX);

  always_comb begin
    ptr_d  = ptr_q;
    held_d = held_q;
    done_d = adv && cur_last && !idx_wr;
    if (idx_wr)   ptr_d = idx_val;
    else if (adv) ptr_d = wrap ? '0 : ptr_q + 1'b1;
    if (idx_wr)                 held_d = 1'b0;
    else if (done_d && gate_en) held_d = 1'b1;
    else if (scan_start)        held_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      held_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (idx_wr || adv) ptr_q <= ptr_d;
      held_q <= held_d;
      done_q <= done_d;
    end
  end

  assign ptr       = ptr_q;
  assign scan_done = done_q;

  // R5: the boundary pulse coincides with the pointer back at the head
  p_done_at_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> (ptr_q == '0));

  // R5: converting a flagged entry yields the pulse next cycle
  p_last_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_pulse && !held_q && scan_en && cur_last && !idx_wr) |=> scan_done);

  // R4: plain step to the following slot
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_pulse && !held_q && scan_en && !cur_last && ptr_q != TOP_IDX && !idx_wr)
    |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R7: index write lands in the pointer
  p_index_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (ptr_q == $past(idx_val)));

  // R8: a hold freezes the pointer
  p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !idx_wr) |=> $stable(ptr_q));

  // R2: static mode leaves the pointer alone
  p_static_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !idx_wr) |=> $stable(ptr_q));
endmodule

// File: rtl/cgs_sequencer.sv
module cgs_sequencer
  import cgs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               conv_pulse,
  input  logic               scan_start,
  output logic               conv_go,
  output logic [CHAN_W-1:0]  mux_sel,
  output logic [GAIN_W-1:0]  gain_code,
  output logic               scan_done
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             scan_en, gate_en, diff_en;
  logic             idx_wr, entry_wr;
  logic [PTR_W-1:0] idx_val, ptr;
  entry_t           static_entry, wr_entry, list_entry, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cgs_cfg_regs #(.PTR_W(PTR_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .scan_en      (scan_en),
    .gate_en      (gate_en),
    .diff_en      (diff_en),
    .static_entry (static_entry),
    .wr_entry     (wr_entry),
    .idx_wr       (idx_wr),
    .idx_val      (idx_val),
    .entry_wr     (entry_wr)
  );

  cgs_entry_ram #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ram (
    .clk   (clk),
    .we    (entry_wr),
    .waddr (ptr),
    .wdata (wr_entry),
    .raddr (ptr),
    .rdata (list_entry)
  );

  cgs_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .scan_en    (scan_en),
    .gate_en    (gate_en),
    .conv_pulse (conv_pulse),
    .scan_start (scan_start),
    .idx_wr     (idx_wr),
    .idx_val    (idx_val),
    .cur_last   (list_entry.last),
    .ptr        (ptr),
    .conv_go    (conv_go),
    .scan_done  (scan_done)
  );

  assign active    = scan_en ? list_entry : static_entry;
  assign gain_code = active.gain;
  assign mux_sel   = diff_en ? {1'b0, active.chan[CHAN_W-2:0]} : active.chan;

  // R1: the boundary pulse never shows while scanning is off
  p_no_done_static_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!scan_en && !$past(scan_en)) |-> !scan_done);
endmodule

// File: tb/cgs_sequencer_tb.sv
module cgs_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;

  typedef struct packed {
    logic [15:0] word;
    logic [3:0]  ch;
    logic [1:0]  gn;
    logic        last;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{16'h0085, 4'd5,  2'd2, 1'b0},
    '{16'h004C, 4'd12, 2'd1, 1'b0},
    '{16'h00C3, 4'd3,  2'd3, 1'b0},
    '{16'h0019, 4'd9,  2'd0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        conv_pulse = 1'b0;
  logic        scan_start = 1'b0;
  logic        conv_go, scan_done;
  logic [3:0]  mux_sel;
  logic [1:0]  gain_code;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cgs_sequencer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .conv_pulse(conv_pulse), .scan_start(scan_start), .conv_go(conv_go),
    .mux_sel(mux_sel), .gain_code(gain_code), .scan_done(scan_done)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step();
    wr_en = 1'b0;
    #1;
  endtask

  task automatic conv();
    conv_pulse = 1'b1;
    step();
    conv_pulse = 1'b0;
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk("R1 mux_sel", int'(mux_sel), 0);
    chk("R1 gain_code", int'(gain_code), 0);
    chk("R1 scan_done", int'(scan_done), 0);
    conv_pulse = 1'b1; #1;
    chk("R10 conv_go follows", int'(conv_go), 1);
    step(); conv_pulse = 1'b0; #1;

    // R2 static mode
    wr(2'd1, 16'h0085);
    chk("R2 static mux", int'(mux_sel), 5);
    chk("R2 static gain", int'(gain_code), 2);
    conv(); conv();
    chk("R2 static after conv", int'(mux_sel), 5);
    chk("R2 no scan_done", int'(scan_done), 0);

    // load list, enable scanning
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, 16'(i));
      wr(2'd1, VECS[i].word);
    end
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'h0000);

    // R4 / R5 vector walk, two passes
    for (int k = 0; k < 8; k++) begin
      chk("R4 mux", int'(mux_sel), int'(VECS[k % 4].ch));
      chk("R4 gain", int'(gain_code), int'(VECS[k % 4].gn));
      conv();
      chk("R5 scan_done", int'(scan_done), int'(VECS[k % 4].last));
    end

    // R3 no auto-increment, neighbour untouched
    wr(2'd0, 16'd2);
    wr(2'd1, 16'h000A);
    wr(2'd1, 16'h00C3);
    chk("R3 overwrite mux", int'(mux_sel), 3);
    chk("R3 overwrite gain", int'(gain_code), 3);
    conv();
    chk("R3 neighbour mux", int'(mux_sel), 9);
    conv();
    chk("R5 done after slot3", int'(scan_done), 1);

    // R7 index write wins over coincident conversion
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'd1; conv_pulse = 1'b1;
    step();
    wr_en = 1'b0; conv_pulse = 1'b0; #1;
    chk("R7 index priority", int'(mux_sel), 12);

    // R6 wrap at highest slot without marker
    wr(2'd0, 16'd4); wr(2'd1, 16'h0001);
    wr(2'd0, 16'd5); wr(2'd1, 16'h0002);
    wr(2'd0, 16'd6); wr(2'd1, 16'h0003);
    wr(2'd0, 16'd7); wr(2'd1, 16'h0004);
    wr(2'd0, 16'd4);
    chk("R6 start mux", int'(mux_sel), 1);
    conv(); conv(); conv();
    chk("R6 top slot mux", int'(mux_sel), 4);
    conv();
    chk("R6 wrapped mux", int'(mux_sel), 5);
    chk("R6 no scan_done", int'(scan_done), 0);

    // R8 scan gate
    wr(2'd2, 16'h0003);
    conv(); conv(); conv(); conv();
    chk("R8 scan_done", int'(scan_done), 1);
    conv_pulse = 1'b1; #1;
    chk("R8 conv_go held", int'(conv_go), 0);
    step(); conv_pulse = 1'b0; #1;
    conv_pulse = 1'b1; step(); conv_pulse = 1'b0; #1;
    chk("R8 pointer frozen", int'(mux_sel), 5);
    scan_start = 1'b1; step(); scan_start = 1'b0; #1;
    conv_pulse = 1'b1; #1;
    chk("R8 conv_go released", int'(conv_go), 1);
    step(); conv_pulse = 1'b0; #1;
    chk("R8 advanced", int'(mux_sel), 12);

    // R7 index write clears hold
    conv(); conv(); conv();
    chk("R8 second done", int'(scan_done), 1);
    wr(2'd0, 16'd2);
    conv_pulse = 1'b1; #1;
    chk("R7 hold cleared", int'(conv_go), 1);
    step(); conv_pulse = 1'b0; #1;
    chk("R7 moved", int'(mux_sel), 9);

    // R9 differential masking
    wr(2'd2, 16'h0005);
    wr(2'd0, 16'd1);
    chk("R9 diff mux", int'(mux_sel), 4);
    chk("R9 diff gain", int'(gain_code), 1);
    wr(2'd2, 16'h0001);
    chk("R9 single-ended mux", int'(mux_sel), 12);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all-requirements act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule